// File: doc/BRIEF.md
# TDM Transmit Slot Sequencer

The sequencer produces the serial transmit line of a time-division multiplexed link, one bit per clock. A frame begins when the frame-sync input is seen high. The block then walks a table of slot entries starting at entry 0. Each entry carries a valid flag, a wrap flag, a last-subchannel flag, a 5-bit channel pointer and an 8-bit mask. Consecutive entries share one 8-bit time slot, so subchannels of different rates can be packed into a single slot.

For each bit position, the sequencer finds the entry that owns that position. If the owner is valid, it asks the channel side for a data bit one bit period ahead. Otherwise it drives an idle high level or releases the line. An output enable lets several devices share an open-drain line: slots owned by an invalid entry are left free for other transmitters.

When the last slot of the table has been sent, the line idles until the next frame sync.

Top module: `tdm_tx_sequencer`

## Requirements
- R1: Entry i sits at `slot_table[16*i +: 16]`. Its fields are bit 15 valid, bit 14 wrap, bit 13 last, bits 12:8 channel pointer and bits 7:0 mask, where mask bit p covers slot bit position p. A slot is made of consecutive entries. It runs from its first entry up to the first entry with last or wrap set, or up to the final table entry. The next slot starts at the entry after that.
- R2: Bits go out MSB-first, one per clock, from position 7 down to 0. Bit 7 of the first slot appears on `tx_data` in the third cycle after the cycle in which `fsync` is high. Each following bit appears one cycle later, with no gap between slots.
- R3: A bit owned by a valid entry is requested in the cycle before it is transmitted. In that cycle `req_valid` is 1 and `req_addr` equals the entry's 5-bit pointer followed by six zero bits. No other bit position raises `req_valid`.
- R4: For a requested bit whose response arrives (`rsp_valid`=1 in the request cycle), the next cycle shows `tx_data`=`rsp_bit` and `tx_en`=1.
- R5: A bit position that no entry of the slot claims through its mask is sent as a driven 1 (`tx_en`=1, `tx_data`=1).
- R6: A bit position owned by an invalid entry is not requested. In push-pull mode (`od_mode`=0) it is driven as 1. In open-drain mode (`od_mode`=1) the line is released (`tx_en`=0, `tx_data`=1).
- R7: The table ends after the slot that holds an entry with wrap set, or after the slot that holds the final table entry. Entries beyond that point are ignored. The line then idles as in R6 until the next `fsync`, which restarts the walk at entry 0.
- R8: If `rsp_valid` is 0 in a request cycle, the bit is sent as a driven 1 and `tx_underrun` is 1 for exactly that bit.
- R9: While `rst_n` is low, `tx_en`=0, `tx_data`=1, `req_valid`=0 and `tx_underrun`=0.
- R10: When several entries of a slot claim the same bit position, the entry with the lowest index owns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; restarts the table walk |
| od_mode | input | 1 | 1 = open-drain sharing, 0 = push-pull |
| slot_table | input | 128 | Slot entries, 16 bits each |
| req_valid | output | 1 | Data bit request |
| req_addr | output | 11 | Channel base address of the request |
| rsp_valid | input | 1 | Response present for the current request |
| rsp_bit | input | 1 | Data bit returned by the channel |
| tx_data | output | 1 | Serial transmit data |
| tx_en | output | 1 | Drive enable for the transmit line |
| tx_underrun | output | 1 | Requested bit was not supplied |

## Verification
Every transmit result lags frame sync by a fixed pipeline: the request for slot bit 7 appears two cycles after the sync cycle, and the bit itself appears three cycles after it. Each later bit follows one cycle after its predecessor, and an underrun flag comes out alongside the bit it concerns.

The monitor skips exactly three falling edges after raising sync and then compares one expected line state per falling edge. The responder answers each request on the falling edge of the request cycle, so the data is captured at the edge that produces the bit.

// File: rtl/tdmtx_pkg.sv
package tdmtx_pkg;

    // What the line does for one bit position
    typedef enum logic [1:0] {
        K_FREE = 2'd0,   // invalid owner or idle: release (open-drain) or drive 1
        K_ONE  = 2'd1,   // unclaimed or masked: drive 1
        K_DATA = 2'd2    // fetch a bit from the channel
    } bit_kind_e;

endpackage

// File: rtl/tdmtx_resolve.sv
module tdmtx_resolve #(
    parameter int N_ENT     = 8,
    parameter int PTR_W     = 5,
    parameter int SLOT_BITS = 8,
    localparam int ENT_W    = 3 + PTR_W + SLOT_BITS,
    localparam int IDX_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int POS_W    = $clog2(SLOT_BITS)
) (
    input  logic [N_ENT*ENT_W-1:0] table_i,
    input  logic [IDX_W-1:0]       base_i,
    input  logic [POS_W-1:0]       pos_i,
    output logic                   found_o,
    output logic [IDX_W-1:0]       owner_o,
    output logic                   owner_valid_o,
    output logic [PTR_W-1:0]       owner_ptr_o,
    output logic [IDX_W-1:0]       gend_o,
    output logic                   gwrap_o
);
    localparam int F_VALID = ENT_W - 1;
    localparam int F_WRAP  = ENT_W - 2;
    localparam int F_LAST  = ENT_W - 3;

    logic [ENT_W-1:0] ent;
    logic [ENT_W-1:0] sel;
    logic             open_c;
    logic             done_c;

    // Scan the slot that starts at base_i: first claimer wins, slot ends at last/wrap/final entry
    always_comb begin
        ent     = '0;
        open_c  = 1'b0;
        done_c  = 1'b0;
        found_o = 1'b0;
        owner_o = '0;
        gend_o  = IDX_W'(N_ENT - 1);
        gwrap_o = 1'b1;
        for (int i = 0; i < N_ENT; i++) begin
            ent = table_i[i*ENT_W +: ENT_W];
            if (IDX_W'(i) == base_i) open_c = 1'b1;
            if (open_c && !done_c) begin
                if (!found_o && ent[pos_i]) begin
                    found_o = 1'b1;
                    owner_o = IDX_W'(i);
                end
                if (ent[F_LAST] || ent[F_WRAP] || (i == N_ENT - 1)) begin
                    done_c  = 1'b1;
                    gend_o  = IDX_W'(i);
                    gwrap_o = ent[F_WRAP] || (i == N_ENT - 1);
                end
            end
        end
    end

    always_comb begin
        sel           = table_i[int'(owner_o)*ENT_W +: ENT_W];
        owner_valid_o = sel[F_VALID];
        owner_ptr_o   = sel[SLOT_BITS +: PTR_W];
    end

endmodule

// File: rtl/tdmtx_seq.sv
module tdmtx_seq
    import tdmtx_pkg::*;
#(
    parameter int N_ENT     = 8,
    parameter int PTR_W     = 5,
    parameter int SLOT_BITS = 8,
    localparam int IDX_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int POS_W    = $clog2(SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    input  logic             found_i,
    input  logic [IDX_W-1:0] owner_i,
    input  logic             owner_valid_i,
    input  logic [PTR_W-1:0] owner_ptr_i,
    input  logic [IDX_W-1:0] gend_i,
    input  logic             gwrap_i,
    output logic [IDX_W-1:0] base_o,
    output logic [POS_W-1:0] pos_o,
    output bit_kind_e        kind_o,
    output logic [PTR_W-1:0] ptr_o
);
    localparam logic [POS_W-1:0] POS_TOP = POS_W'(SLOT_BITS - 1);

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] base;
        logic [POS_W-1:0] pos;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fsync_i) begin
            st_d.active = 1'b1;
            st_d.base   = '0;
            st_d.pos    = POS_TOP;
        end else if (st_q.active) begin
            if (st_q.pos == '0) begin
                if (gwrap_i) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.base = gend_i + IDX_W'(1);
                    st_d.pos  = POS_TOP;
                end
            end else begin
                st_d.pos = st_q.pos - POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, base: '0, pos: POS_TOP};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        base_o = st_q.base;
        pos_o  = st_q.pos;
        ptr_o  = owner_ptr_i;
        if (!st_q.active)      kind_o = K_FREE;
        else if (!found_i)     kind_o = K_ONE;
        else if (owner_valid_i) kind_o = K_DATA;
        else                   kind_o = K_FREE;
    end

    // R2
    fsync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> (st_q.active && st_q.base == '0 && st_q.pos == POS_TOP));

    // R2
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.pos != '0 && !fsync_i) |=>
            (st_q.pos == $past(st_q.pos) - POS_W'(1) && st_q.base == $past(st_q.base)));

    // R10
    owner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && found_i) |-> (owner_i >= st_q.base && owner_i <= gend_i));

    // R7
    wrap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.pos == '0 && gwrap_i && !fsync_i) |=> !st_q.active);

endmodule

// File: rtl/tdmtx_out.sv
module tdmtx_out
    import tdmtx_pkg::*;
#(
    parameter int PTR_W    = 5,
    parameter int ZERO_LSB = 6,
    localparam int ADDR_W  = PTR_W + ZERO_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              od_mode_i,
    input  bit_kind_e         kind_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic              rsp_valid_i,
    input  logic              rsp_bit_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic              tx_data_o,
    output logic              tx_en_o,
    output logic              underrun_o
);
    typedef struct packed {
        bit_kind_e        kind;
        logic [PTR_W-1:0] ptr;
        logic             tx_data;
        logic             tx_en;
        logic             under;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kind = kind_i;
        st_d.ptr  = ptr_i;
        unique case (st_q.kind)
            K_DATA: begin
                st_d.tx_data = rsp_valid_i ? rsp_bit_i : 1'b1;
                st_d.tx_en   = 1'b1;
                st_d.under   = !rsp_valid_i;
            end
            K_ONE: begin
                st_d.tx_data = 1'b1;
                st_d.tx_en   = 1'b1;
                st_d.under   = 1'b0;
            end
            default: begin
                st_d.tx_data = 1'b1;
                st_d.tx_en   = !od_mode_i;
                st_d.under   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{kind: K_FREE, ptr: '0, tx_data: 1'b1, tx_en: 1'b0, under: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid_o = (st_q.kind == K_DATA);
    assign req_addr_o  = {st_q.ptr, {ZERO_LSB{1'b0}}};
    assign tx_data_o   = st_q.tx_data;
    assign tx_en_o     = st_q.tx_en;
    assign underrun_o  = st_q.under;

    // R4
    req_then_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |=> tx_en_o);

    // R8
    miss_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !rsp_valid_i) |=> (underrun_o && tx_data_o));

    // R8
    underrun_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> (tx_data_o && tx_en_o));

    // R6
    released_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_o |-> tx_data_o);

endmodule

// File: rtl/tdm_tx_sequencer.sv
module tdm_tx_sequencer
    import tdmtx_pkg::*;
#(
    parameter int N_ENT     = 8,
    parameter int PTR_W     = 5,
    parameter int SLOT_BITS = 8,
    parameter int ZERO_LSB  = 6,
    localparam int ENT_W    = 3 + PTR_W + SLOT_BITS,
    localparam int ADDR_W   = PTR_W + ZERO_LSB,
    localparam int IDX_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int POS_W    = $clog2(SLOT_BITS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fsync,
    input  logic                   od_mode,
    input  logic [N_ENT*ENT_W-1:0] slot_table,
    output logic                   req_valid,
    output logic [ADDR_W-1:0]      req_addr,
    input  logic                   rsp_valid,
    input  logic                   rsp_bit,
    output logic                   tx_data,
    output logic                   tx_en,
    output logic                   tx_underrun
);
    logic             found;
    logic [IDX_W-1:0] owner;
    logic             owner_valid;
    logic [PTR_W-1:0] owner_ptr;
    logic [IDX_W-1:0] gend;
    logic             gwrap;
    logic [IDX_W-1:0] base;
    logic [POS_W-1:0] pos;
    bit_kind_e        kind;
    logic [PTR_W-1:0] kptr;

    tdmtx_resolve #(.N_ENT(N_ENT), .PTR_W(PTR_W), .SLOT_BITS(SLOT_BITS)) u_resolve (
        .table_i       (slot_table),
        .base_i        (base),
        .pos_i         (pos),
        .found_o       (found),
        .owner_o       (owner),
        .owner_valid_o (owner_valid),
        .owner_ptr_o   (owner_ptr),
        .gend_o        (gend),
        .gwrap_o       (gwrap)
    );

    tdmtx_seq #(.N_ENT(N_ENT), .PTR_W(PTR_W), .SLOT_BITS(SLOT_BITS)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .fsync_i       (fsync),
        .found_i       (found),
        .owner_i       (owner),
        .owner_valid_i (owner_valid),
        .owner_ptr_i   (owner_ptr),
        .gend_i        (gend),
        .gwrap_i       (gwrap),
        .base_o        (base),
        .pos_o         (pos),
        .kind_o        (kind),
        .ptr_o         (kptr)
    );

    tdmtx_out #(.PTR_W(PTR_W), .ZERO_LSB(ZERO_LSB)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .od_mode_i   (od_mode),
        .kind_i      (kind),
        .ptr_i       (kptr),
        .rsp_valid_i (rsp_valid),
        .rsp_bit_i   (rsp_bit),
        .req_valid_o (req_valid),
        .req_addr_o  (req_addr),
        .tx_data_o   (tx_data),
        .tx_en_o     (tx_en),
        .underrun_o  (tx_underrun)
    );

endmodule

// File: tb/tb_tdm_tx_sequencer.sv
module tb_tdm_tx_sequencer;
    localparam int N  = 8;
    localparam int EW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0;
    logic          od_mode = 1'b0;
    logic [N*EW-1:0] slot_table = '0;
    logic          req_valid;
    logic [10:0]   req_addr;
    logic          rsp_valid = 1'b0;
    logic          rsp_bit = 1'b0;
    logic          tx_data;
    logic          tx_en;
    logic          tx_underrun;

    int checks = 0;
    int fails  = 0;
    int skip   = 0;
    int rk     = 0;
    int drop_idx = -1;

    logic [2:0]  exp_q[$];   // {tx_en, tx_data, tx_underrun}
    string       tag_q[$];
    logic [10:0] addr_q[$];

    always #2 clk = ~clk;   // 250 MHz

    tdm_tx_sequencer dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .od_mode(od_mode),
        .slot_table(slot_table), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_bit(rsp_bit), .tx_data(tx_data),
        .tx_en(tx_en), .tx_underrun(tx_underrun)
    );

    function automatic logic [15:0] mk(bit v, bit w, bit l, logic [4:0] p, logic [7:0] m);
        return {v, w, l, p, m};
    endfunction

    function automatic bit chan_bit(logic [4:0] p, int k);
        return p[0] ^ k[0] ^ k[1];
    endfunction

    // Model from R1, R2, R5, R6, R7, R8, R10
    task automatic build_frame(input logic [N*EW-1:0] tbl, input bit od, input int drop);
        int base = 0;
        int k = 0;
        bit gw = 1'b0;
        int gend = N - 1;
        while (1) begin
            for (int pos = 7; pos >= 0; pos--) begin
                int own = -1;
                logic [15:0] e;
                for (int i = base; i < N; i++) begin
                    e = tbl[i*EW +: EW];
                    if (own < 0 && e[pos]) own = i;   // R10 lowest index wins
                    if (e[13] || e[14] || i == N - 1) begin
                        gend = i;
                        gw = e[14] || (i == N - 1);
                        break;
                    end
                end
                if (own < 0) begin
                    exp_q.push_back(3'b110); tag_q.push_back("R5 unclaimed");
                end else begin
                    e = tbl[own*EW +: EW];
                    if (!e[15]) begin
                        exp_q.push_back({!od, 1'b1, 1'b0}); tag_q.push_back("R6 invalid owner");
                    end else begin
                        addr_q.push_back({e[12:8], 6'b0});
                        if (k == drop) begin
                            exp_q.push_back(3'b111); tag_q.push_back("R8 underrun");
                        end else begin
                            exp_q.push_back({1'b1, chan_bit(e[12:8], k), 1'b0});
                            tag_q.push_back("R2 R4 R10 data");
                        end
                        k++;
                    end
                end
            end
            if (gw) break;
            base = gend + 1;
        end
        for (int j = 0; j < 4; j++) begin
            exp_q.push_back({!od, 1'b1, 1'b0}); tag_q.push_back("R7 idle");
        end
    endtask

    task automatic run_frame(input logic [N*EW-1:0] tbl, input bit od, input int drop);
        @(posedge clk); #1;
        slot_table = tbl;
        od_mode    = od;
        drop_idx   = drop;
        rk         = 0;
        build_frame(tbl, od, drop);
        skip  = 3;
        fsync = 1'b1;
        @(posedge clk); #1;
        fsync = 1'b0;
        while (exp_q.size() != 0) @(posedge clk);
        checks++;
        if (addr_q.size() != 0) begin
            fails++;
            $display("FAIL R3 missing requests: actual %0d outstanding, expected 0", addr_q.size());
            addr_q.delete();
        end
    endtask

    // Monitor: one expected line state per falling edge
    always @(negedge clk) begin
        if (skip > 0) begin
            skip--;
        end else if (exp_q.size() > 0) begin
            logic [2:0] ex;
            string tg;
            ex = exp_q.pop_front();
            tg = tag_q.pop_front();
            checks++;
            if ({tx_en, tx_data, tx_underrun} !== ex) begin
                fails++;
                $display("FAIL %s: actual en/data/under=%b expected %b", tg,
                         {tx_en, tx_data, tx_underrun}, ex);
            end
        end
    end

    // Responder: answers on the falling edge of the request cycle (R3)
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            checks++;
            if (addr_q.size() == 0) begin
                fails++;
                $display("FAIL R3 R1 unexpected request: actual addr %h, expected none", req_addr);
            end else begin
                logic [10:0] ea;
                ea = addr_q.pop_front();
                if (req_addr !== ea) begin
                    fails++;
                    $display("FAIL R3 R1 request address: actual %h expected %h", req_addr, ea);
                end
            end
            if (rk == drop_idx) begin
                rsp_valid = 1'b0;
            end else begin
                rsp_valid = 1'b1;
                rsp_bit   = chan_bit(req_addr[10:6], rk);
            end
            rk++;
        end else begin
            rsp_valid = 1'b0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [N*EW-1:0] ta, tc, td;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        checks += 4;
        if (tx_en !== 1'b0)       begin fails++; $display("FAIL R9 tx_en: actual %b expected 0", tx_en); end
        if (tx_data !== 1'b1)     begin fails++; $display("FAIL R9 tx_data: actual %b expected 1", tx_data); end
        if (req_valid !== 1'b0)   begin fails++; $display("FAIL R9 req_valid: actual %b expected 0", req_valid); end
        if (tx_underrun !== 1'b0) begin fails++; $display("FAIL R9 tx_underrun: actual %b expected 0", tx_underrun); end
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // Frame A: full slot, two overlapping subchannels (R10), unclaimed bits (R5), invalid wrap slot (R6)
        ta = '0;
        ta[0*EW +: EW] = mk(1, 0, 1, 5'd3, 8'hFF);
        ta[1*EW +: EW] = mk(1, 0, 0, 5'd5, 8'hF0);
        ta[2*EW +: EW] = mk(1, 0, 1, 5'd9, 8'h3C);
        ta[3*EW +: EW] = mk(0, 1, 1, 5'd1, 8'hFF);
        ta[4*EW +: EW] = mk(1, 0, 1, 5'd7, 8'hFF);   // past wrap: ignored (R7)
        run_frame(ta, 1'b0, -1);
        // Same table, open-drain (R6, R7)
        run_frame(ta, 1'b1, -1);

        // Frame C: sparse mask, wrap without last, underrun on third request (R8)
        tc = '0;
        tc[0*EW +: EW] = mk(1, 0, 1, 5'd2, 8'hA5);
        tc[1*EW +: EW] = mk(1, 1, 0, 5'd4, 8'hFF);
        tc[2*EW +: EW] = mk(1, 0, 1, 5'd6, 8'hFF);
        run_frame(tc, 1'b0, 2);

        // Frame D: no wrap flag, table ends at final entry (R7); mixed invalid slots in open-drain
        td = '0;
        for (int i = 0; i < N; i++)
            td[i*EW +: EW] = mk(i[0], 0, 1, 5'(i + 16), (i == 2) ? 8'h0F : 8'hFF);
        run_frame(td, 1'b1, -1);
        run_frame(td, 1'b0, 5);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule